// File: doc/BRIEF.md
# Gated 13/16-bit Timer-Counter

This block is a timer/counter peripheral for a microcontroller subsystem. It advances a pair of byte-wide count registers. The count source is either a peripheral clock-enable strobe or falling edges on an external count pin. Counting is enabled by a run bit. Setting a gate bit also makes counting depend on an external gate pin, which is synchronized before use. When the full count wraps from all ones to all zeros, an overflow flag is set, and the flag drives the interrupt request output.

Two counting arrangements exist. In the prescaled mode, the five low bits of the low byte act as a divide-by-32 prescaler that feeds an 8-bit high byte. In the cascaded mode, both bytes form one 16-bit counter. Software reads and writes the two count bytes, the mode register and the control register through a simple register port. The combinational read data follows the address. A write takes effect at the clock edge where the write enable is high.

Top module: `gtc_timer`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_req` is low.
- R2: The register addresses are 0 = low count byte, 1 = high count byte, 2 = mode, 3 = control.
  - Mode bits: bit 3 = gate enable, bit 2 = source select, bits 1:0 = mode.
  - Control bits: bit 5 = overflow flag, bit 4 = run, bit 1 = external-interrupt flag, bit 0 = interrupt-type select.
  - Every other bit of the mode and control registers reads 0.
- R3: With source select = 0, the count advances by one at each clock edge where `tick_en` is high and counting is enabled.
- R4: With source select = 1, `tick_en` is ignored. The count advances once for each high-to-low transition of `cnt_pin`, at the third rising clock edge after the pin falls. A rising transition has no effect.
- R5: While run = 0, the count does not change.
- R6: With gate enable = 1, counting also requires `gate_pin` high.
  - `gate_pin` passes through a two-stage synchronizer, so counting starts at the third rising edge after the pin rises.
  - Counting continues for two edges after the pin falls.
- R7: In mode 01, the low byte and the high byte form one 16-bit counter. A carry out of the low byte increments the high byte.
- R8: In mode 00, low-byte bits 4:0 form a modulo-32 prescaler whose wrap increments the high byte. Low-byte bits 7:5 are left unchanged by counting and play no part in carry or overflow.
- R9: A wrap of the full count to zero sets the overflow flag, and `irq_req` equals the flag.
- R10: Writing the control register loads the overflow flag from bit 5, and a high `irq_ack` clears the flag. A wrap in the same cycle takes priority over both.
- R11: In modes 10 and 11, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tick_en | input | 1 | Peripheral clock enable, the count source when source select = 0 |
| cnt_pin | input | 1 | External event pin, asynchronous |
| gate_pin | input | 1 | External gate pin, asynchronous |
| irq_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| irq_req | output | 1 | Overflow interrupt request |

## Verification
Most internal faults reach the ports within one clock edge.
- A wrong carry between the prescaler and the high byte shows in the high byte on the edge after the low field wraps.
- A missed or misplaced wrap shows on `irq_req` on the same edge.

Synchronizer faults are slower to surface. A wrong synchronizer depth, or a wrong edge sense on the count pin, shifts the first count by whole cycles, so the bench samples the count on the exact edge where it should first move. The upper low-byte bits in the prescaled mode are preloaded with ones, so that a carry taken from the whole byte becomes visible.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_CTL  = 2'd3;

  localparam int CTL_ITYPE = 0;
  localparam int CTL_XFLAG = 1;
  localparam int CTL_RUN   = 4;
  localparam int CTL_OVF   = 5;

  localparam int MD_GATE = 3;
  localparam int MD_SRC  = 2;

  typedef enum logic [1:0] {
    CM_PRESCALE = 2'b00,
    CM_CASCADE  = 2'b01,
    CM_IDLE_A   = 2'b10,
    CM_IDLE_B   = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic              wrap;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } step_t;

  // One count step for the selected arrangement.
  function automatic step_t count_step(cnt_mode_e m, logic [BYTE_W-1:0] lo,
                                       logic [BYTE_W-1:0] hi);
    step_t            s;
    logic [BYTE_W:0]  lo_sum;
    logic [PRE_W-1:0] pre;
    logic             pre_carry;
    s = '{wrap: 1'b0, hi: hi, lo: lo};
    case (m)
      CM_PRESCALE: begin
        pre       = lo[PRE_W-1:0] + 1'b1;
        pre_carry = &lo[PRE_W-1:0];
        s.lo      = {lo[BYTE_W-1:PRE_W], pre};
        s.hi      = hi + {{(BYTE_W-1){1'b0}}, pre_carry};
        s.wrap    = pre_carry & (&hi);
      end
      CM_CASCADE: begin
        lo_sum = {1'b0, lo} + 1'b1;
        s.lo   = lo_sum[BYTE_W-1:0];
        s.hi   = hi + {{(BYTE_W-1){1'b0}}, lo_sum[BYTE_W]};
        s.wrap = (&lo) & (&hi);
      end
      default: s.wrap = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/gtc_event.sv
module gtc_event (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic pin_s,
  input  logic gate_s,
  input  logic run,
  input  logic gate_bit,
  input  logic src_sel,
  output logic count_ok,
  output logic inc
);
  logic pin_prev;
  logic pin_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= 1'b0;
    else        pin_prev <= pin_s;
  end

  assign pin_fall = pin_prev & ~pin_s;
  assign count_ok = run & (~gate_bit | gate_s);
  assign inc      = count_ok & (src_sel ? pin_fall : tick_en);
endmodule

// File: rtl/gtc_core.sv
module gtc_core
  import gtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cnt_mode_e         mode,
  input  logic              inc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              wrap
);
  step_t nxt;
  logic  sw_write;

  always_comb nxt = count_step(mode, lo, hi);

  assign sw_write = wr_lo | wr_hi;
  assign wrap     = inc & ~sw_write & nxt.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (sw_write) begin
      if (wr_lo) lo <= wdata;
      if (wr_hi) hi <= wdata;
    end else if (inc) begin
      lo <= nxt.lo;
      hi <= nxt.hi;
    end
  end
endmodule

// File: rtl/gtc_timer.sv
module gtc_timer
  import gtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick_en,
  input  logic       cnt_pin,
  input  logic       gate_pin,
  input  logic       irq_ack,
  output logic       irq_req
);
  logic [3:0]        mode_q;
  logic              itype_q, xflag_q, run_q, ovf_q;
  logic              gate_s, pin_s;
  logic              count_ok, inc, wrap;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi;
  logic              wr_lo, wr_hi, wr_mode, wr_ctl;

  assign wr_lo   = reg_we && reg_addr == ADDR_LO;
  assign wr_hi   = reg_we && reg_addr == ADDR_HI;
  assign wr_mode = reg_we && reg_addr == ADDR_MODE;
  assign wr_ctl  = reg_we && reg_addr == ADDR_CTL;

  gtc_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .d(gate_pin), .q(gate_s));
  gtc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(cnt_pin), .q(pin_s));

  gtc_event u_event (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pin_s(pin_s),
    .gate_s(gate_s), .run(run_q), .gate_bit(mode_q[MD_GATE]),
    .src_sel(mode_q[MD_SRC]), .count_ok(count_ok), .inc(inc));

  gtc_core u_core (
    .clk(clk), .rst_n(rst_n), .mode(cnt_mode_e'(mode_q[1:0])), .inc(inc),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(reg_wdata),
    .lo(cnt_lo), .hi(cnt_hi), .wrap(wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      itype_q <= 1'b0;
      xflag_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[3:0];
      if (wr_ctl) begin
        itype_q <= reg_wdata[CTL_ITYPE];
        xflag_q <= reg_wdata[CTL_XFLAG];
        run_q   <= reg_wdata[CTL_RUN];
      end
    end
  end

  // Overflow flag: a wrap outranks a software write, which outranks an acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (wrap)    ovf_q <= 1'b1;
    else if (wr_ctl)  ovf_q <= reg_wdata[CTL_OVF];
    else if (irq_ack) ovf_q <= 1'b0;
  end

  assign irq_req = ovf_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_LO:   reg_rdata = cnt_lo;
      ADDR_HI:   reg_rdata = cnt_hi;
      ADDR_MODE: reg_rdata[3:0] = mode_q;
      default: begin
        reg_rdata[CTL_ITYPE] = itype_q;
        reg_rdata[CTL_XFLAG] = xflag_q;
        reg_rdata[CTL_RUN]   = run_q;
        reg_rdata[CTL_OVF]   = ovf_q;
      end
    endcase
  end
endmodule

// File: rtl/gtc_timer_chk.sv
module gtc_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] cnt_lo,
  input logic [7:0] cnt_hi,
  input logic [3:0] mode_q,
  input logic       run_q,
  input logic       gate_s,
  input logic       inc,
  input logic       wrap,
  input logic       irq_ack,
  input logic       irq_req
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reg_we) |=> $stable({cnt_hi, cnt_lo})); // R5
  AST_GATE_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3] && !gate_s && !reg_we) |=> $stable({cnt_hi, cnt_lo})); // R6
  AST_IDLE_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && !reg_we) |=> $stable({cnt_hi, cnt_lo})); // R11
  AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !reg_we && mode_q[1:0] == 2'b01)
      |=> {cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 16'd1); // R7
  AST_PRESCALE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode_q[1:0] == 2'b00) |=> (cnt_lo[4:0] == 5'd0 && cnt_hi == 8'd0)); // R8
  AST_WRAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> irq_req); // R9
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wrap && !(reg_we && reg_addr == 2'd3)) |=> !irq_req); // R10
endmodule

bind gtc_timer gtc_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .mode_q(mode_q), .run_q(run_q),
  .gate_s(gate_s), .inc(inc), .wrap(wrap), .irq_ack(irq_ack),
  .irq_req(irq_req));

// File: tb/gtc_timer_test.sv
module gtc_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_en = 1'b0, cnt_pin = 1'b0, gate_pin = 1'b0, irq_ack = 1'b0;
  logic       irq_req;
  int         n_run = 0, n_fail = 0;
  logic [7:0] rv;

  always #10 clk = ~clk; // 50 MHz

  gtc_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin), .irq_ack(irq_ack),
    .irq_req(irq_req));

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] lo, hi, ticks, elo, ehi;
    logic       eovf;
  } vec_t;

  // mode, preload lo/hi, ticks -> expected lo/hi/overflow
  localparam vec_t VECS [8] = '{
    '{2'b01, 8'h00, 8'h00, 8'd5,  8'h05, 8'h00, 1'b0},  // R7 plain
    '{2'b01, 8'hFE, 8'h00, 8'd3,  8'h01, 8'h01, 1'b0},  // R7 carry
    '{2'b01, 8'hFE, 8'hFF, 8'd3,  8'h01, 8'h00, 1'b1},  // R9 16-bit wrap
    '{2'b00, 8'h1E, 8'h00, 8'd3,  8'h01, 8'h01, 1'b0},  // R8 prescaler carry
    '{2'b00, 8'hE0, 8'h00, 8'd33, 8'hE1, 8'h01, 1'b0},  // R8 upper bits kept
    '{2'b00, 8'hFD, 8'hFF, 8'd3,  8'hE0, 8'h00, 1'b1},  // R8 13-bit wrap
    '{2'b00, 8'h1F, 8'h7F, 8'd1,  8'h00, 8'h80, 1'b0},  // R8 single step
    '{2'b10, 8'h10, 8'h20, 8'd5,  8'h10, 8'h20, 1'b0}   // R11 idle mode
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic load(input logic [3:0] md, input logic [7:0] lo,
                      input logic [7:0] hi, input logic [7:0] ctl);
    wr(2'd3, 8'h00);
    wr(2'd2, {4'h0, md});
    wr(2'd0, lo);
    wr(2'd1, hi);
    wr(2'd3, ctl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv); chk("R1 reset reg", rv, 8'h00);
    end
    chk("R1 reset irq", {7'b0, irq_req}, 8'h00);

    // Vector table: R3 timer source with R7/R8/R9/R11 arrangements
    for (int i = 0; i < 8; i++) begin
      load({2'b00, VECS[i].mode}, VECS[i].lo, VECS[i].hi, 8'h10);
      tick_en = 1'b1;
      repeat (VECS[i].ticks) @(negedge clk);
      tick_en = 1'b0;
      rd(2'd0, rv); chk("R3 vec lo", rv, VECS[i].elo);
      rd(2'd1, rv); chk("R3 vec hi", rv, VECS[i].ehi);
      chk("R9 vec irq", {7'b0, irq_req}, {7'b0, VECS[i].eovf});
    end

    // R2 register map and unused bits
    wr(2'd2, 8'hFF); rd(2'd2, rv); chk("R2 mode readback", rv, 8'h0F);
    wr(2'd3, 8'hCF); rd(2'd3, rv); chk("R2 ctl unused bits", rv, 8'h03);
    wr(2'd3, 8'h33); rd(2'd3, rv); chk("R2 ctl readback", rv, 8'h33);
    wr(2'd3, 8'h00);

    // R5 run bit low
    load(4'h1, 8'h40, 8'h00, 8'h00);
    tick_en = 1'b1; repeat (8) @(negedge clk); tick_en = 1'b0;
    rd(2'd0, rv); chk("R5 stopped", rv, 8'h40);

    // R6 gate with synchronizer latency
    load(4'h9, 8'h00, 8'h00, 8'h10);
    tick_en = 1'b1;
    repeat (10) @(negedge clk);
    peek(2'd0, rv); chk("R6 gate closed", rv, 8'h00);
    gate_pin = 1'b1;
    repeat (4) @(negedge clk);
    peek(2'd0, rv); chk("R6 gate open latency", rv, 8'h02);
    repeat (3) @(negedge clk);
    gate_pin = 1'b0;
    repeat (6) @(negedge clk);
    peek(2'd0, rv); chk("R6 gate close latency", rv, 8'h07);
    tick_en = 1'b0;

    // R4 external events, tick_en held high and ignored
    load(4'h5, 8'h00, 8'h00, 8'h10);
    tick_en = 1'b1;
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
    peek(2'd0, rv); chk("R4 rising ignored", rv, 8'h00);
    cnt_pin = 1'b0;
    repeat (2) @(negedge clk);
    peek(2'd0, rv); chk("R4 before third edge", rv, 8'h00);
    @(negedge clk);
    peek(2'd0, rv); chk("R4 at third edge", rv, 8'h01);
    for (int p = 0; p < 3; p++) begin
      cnt_pin = 1'b1; repeat (4) @(negedge clk);
      cnt_pin = 1'b0; repeat (4) @(negedge clk);
    end
    peek(2'd0, rv); chk("R4 event count", rv, 8'h04);
    tick_en = 1'b0;

    // R10 flag set, acknowledge and clear
    wr(2'd3, 8'h20);
    chk("R10 write sets", {7'b0, irq_req}, 8'h01);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R10 ack clears", {7'b0, irq_req}, 8'h00);
    wr(2'd3, 8'h20); wr(2'd3, 8'h00);
    chk("R10 write clears", {7'b0, irq_req}, 8'h00);
    load(4'h1, 8'hFF, 8'hFF, 8'h10);
    tick_en = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; irq_ack = 1'b0;
    #1 chk("R10 wrap beats ack", {7'b0, irq_req}, 8'h01);
    rd(2'd0, rv); chk("R9 wrap to zero", rv, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule